// File: doc/BRIEF.md
# Receive-Path Anticlipping Gain Limiter

This block sits in the receive voice path ahead of a loudspeaker amplifier. It takes 16-bit linear samples that arrive at 8 kHz and measures the size of each one before any gain is applied. It compares that size with one of four selectable trip levels. When a sample is above the trip level, the block adds one 0.5 dB step of digital attenuation. This attack can act on every sample. When samples stay below the trip level, the attenuation is removed one step at a time at a slow, selectable release rate. The release is paced by a divider that counts the 8 kHz tick.

The limiter can only reduce gain. At zero attenuation the samples leave the block bit-exact. There are four trip levels. The lowest keeps distortion well under 1 %, the second aims at about 1 %, and the two highest give up distortion for more output in noisy surroundings. When the enable is low, the block is a plain two-cycle delay line and holds its attenuation at zero.

Top module: `anticlip_limiter`

## Requirements
- R1: After synchronous reset, `atten_o` is 0 and `sample_vld_o` is 0.
- R2: A valid sample counts as loud when |x| > T. Here T = round((2^(DW-1)-1) * 10^((L-3.14)/20)). `thr_sel_i` picks L: 0 gives -15, 1 gives -13, 2 gives -9 and 3 gives -7 (dBm0). A sample equal to T is not loud.
- R3: While enabled, each loud sample raises `atten_o` by exactly 1, which is a 0.5 dB step. The new value is visible after the second rising edge following the cycle in which the sample is presented.
- R4: `atten_o` saturates at MAX_STEPS (24, which is 12 dB). Further loud samples leave it there.
- R5: With no loud sample, one release step of -1 happens on every N-th tick. N is selected by `rel_sel_i`: 0 gives REL_DIV0, 1 gives REL_DIV1, 2 gives REL_DIV2 and 3 gives REL_DIV3 (defaults 2000, 1000, 258 and 129). Each loud sample restarts the tick count.
- R6: `atten_o` never goes below 0, so the gain never rises above unity.
- R7: Each valid input produces one `sample_vld_o` pulse two cycles later. The output value is floor(x*g/32768), where g = round(32768*10^(-a/40)) and a is the attenuation held before that sample's own attack decision.
- R8: While `en_i` is low, the attenuation and the release count are cleared on every edge, and samples leave the block unchanged.
- R9: If a loud sample and a release step are due on the same edge, the attack wins and the release count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | DW | Signed linear receive sample |
| sample_vld_i | input | 1 | Sample strobe |
| thr_sel_i | input | 2 | Trip level select |
| rel_sel_i | input | 2 | Release rate select |
| en_i | input | 1 | Limiter enable |
| tick_i | input | 1 | 8 kHz pacing pulse |
| sample_o | output | DW | Gain-scaled sample |
| sample_vld_o | output | 1 | Output strobe |
| atten_o | output | AW | Attenuation in 0.5 dB steps |

## Verification
The bench keeps the default 16-bit samples and the 24-step ceiling. It replaces the four release divisors with 12, 8, 5 and 3. With these values, a full release from 12 dB back to unity takes only a few hundred cycles, so the divider wraps many times. Collisions between an attack and a due release step also become frequent, which exercises R9. The default divisors would need tens of thousands of ticks for a single full release.

// File: rtl/aclip_pkg.sv
package aclip_pkg;

  // Linear peak level for a trip point given in dBm0 (full-scale sine = +3.14 dBm0)
  function automatic int unsigned trip_level(input int sel, input int dw);
    real db;
    real fs;
    case (sel)
      0:       db = -15.0;
      1:       db = -13.0;
      2:       db = -9.0;
      default: db = -7.0;
    endcase
    fs = real'((1 << (dw - 1)) - 1);
    return $rtoi(fs * (10.0 ** ((db - 3.14) / 20.0)) + 0.5);
  endfunction

  // Q1.15 linear gain for k half-decibel steps of attenuation
  function automatic int unsigned step_gain(input int k);
    return $rtoi(32768.0 * (10.0 ** (-(real'(k)) / 40.0)) + 0.5);
  endfunction

  localparam int GAIN_W = 17;

endpackage

// File: rtl/aclip_detector.sv
module aclip_detector #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sample_i,
  input  logic          sample_vld_i,
  input  logic [1:0]    thr_sel_i,
  input  logic          en_i,
  output logic [DW-1:0] det_sample_o,
  output logic          det_vld_o,
  output logic          det_loud_o,
  output logic          det_en_o
);
  import aclip_pkg::*;

  localparam int MAG_W = DW + 1;

  logic [MAG_W-1:0] trip_tab [4];
  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] trip_sel;

  for (genvar g = 0; g < 4; g++) begin : g_trip
    localparam int unsigned TRIP = trip_level(g, DW);
    assign trip_tab[g] = MAG_W'(TRIP);
  end

  always_comb begin
    if (sample_i[DW-1]) mag = MAG_W'(~{sample_i[DW-1], sample_i}) + MAG_W'(1);
    else                mag = {1'b0, sample_i};
    trip_sel = trip_tab[thr_sel_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_sample_o <= '0;
      det_vld_o    <= 1'b0;
      det_loud_o   <= 1'b0;
      det_en_o     <= 1'b0;
    end else begin
      det_vld_o <= sample_vld_i;
      det_en_o  <= en_i;
      if (sample_vld_i) begin
        det_sample_o <= sample_i;
        det_loud_o   <= (mag > trip_sel);
      end
    end
  end

endmodule

// File: rtl/aclip_gain_ctrl.sv
module aclip_gain_ctrl #(
  parameter int MAX_STEPS = 24,
  parameter int REL_DIV0  = 2000,
  parameter int REL_DIV1  = 1000,
  parameter int REL_DIV2  = 258,
  parameter int REL_DIV3  = 129,
  parameter int AW        = $clog2(MAX_STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [1:0]    rel_sel_i,
  input  logic          attack_i,
  output logic [AW-1:0] atten_o
);

  localparam int DIV_MAX01 = (REL_DIV0 > REL_DIV1) ? REL_DIV0 : REL_DIV1;
  localparam int DIV_MAX23 = (REL_DIV2 > REL_DIV3) ? REL_DIV2 : REL_DIV3;
  localparam int DIV_MAX   = (DIV_MAX01 > DIV_MAX23) ? DIV_MAX01 : DIV_MAX23;
  localparam int CW        = $clog2(DIV_MAX + 1);
  localparam logic [AW-1:0] TOP = AW'(MAX_STEPS);

  logic [CW-1:0] tick_cnt;
  logic [CW-1:0] div_last;
  logic          rel_due;

  always_comb begin
    case (rel_sel_i)
      2'd0:    div_last = CW'(REL_DIV0 - 1);
      2'd1:    div_last = CW'(REL_DIV1 - 1);
      2'd2:    div_last = CW'(REL_DIV2 - 1);
      default: div_last = CW'(REL_DIV3 - 1);
    endcase
    rel_due = tick_i && (tick_cnt >= div_last);
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      atten_o  <= '0;
      tick_cnt <= '0;
    end else if (attack_i) begin
      tick_cnt <= '0;
      if (atten_o != TOP) atten_o <= atten_o + AW'(1);
    end else if (rel_due) begin
      tick_cnt <= '0;
      if (atten_o != '0) atten_o <= atten_o - AW'(1);
    end else if (tick_i) begin
      tick_cnt <= tick_cnt + CW'(1);
    end
  end

endmodule

// File: rtl/aclip_scaler.sv
module aclip_scaler #(
  parameter int DW        = 16,
  parameter int MAX_STEPS = 24,
  parameter int AW        = $clog2(MAX_STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sample_i,
  input  logic          vld_i,
  input  logic          en_i,
  input  logic [AW-1:0] atten_i,
  output logic [DW-1:0] sample_o,
  output logic          vld_o
);
  import aclip_pkg::*;

  localparam int PW = DW + GAIN_W + 1;

  logic [GAIN_W-1:0]   gain_tab [MAX_STEPS+1];
  logic [GAIN_W-1:0]   gain;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;

  for (genvar k = 0; k <= MAX_STEPS; k++) begin : g_gain
    localparam int unsigned G = step_gain(k);
    assign gain_tab[k] = GAIN_W'(G);
  end

  always_comb begin
    gain    = en_i ? gain_tab[atten_i] : gain_tab[0];
    prod    = PW'($signed(sample_i)) * $signed({1'b0, gain});
    shifted = prod >>> 15;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) sample_o <= shifted[DW-1:0];
    end
  end

endmodule

// File: rtl/anticlip_limiter.sv
module anticlip_limiter #(
  parameter int DW        = 16,
  parameter int MAX_STEPS = 24,
  parameter int REL_DIV0  = 2000,
  parameter int REL_DIV1  = 1000,
  parameter int REL_DIV2  = 258,
  parameter int REL_DIV3  = 129,
  parameter int AW        = $clog2(MAX_STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sample_i,
  input  logic          sample_vld_i,
  input  logic [1:0]    thr_sel_i,
  input  logic [1:0]    rel_sel_i,
  input  logic          en_i,
  input  logic          tick_i,
  output logic [DW-1:0] sample_o,
  output logic          sample_vld_o,
  output logic [AW-1:0] atten_o
);

  logic [DW-1:0] det_sample;
  logic          det_vld;
  logic          det_loud;
  logic          det_en;
  logic          attack_req;

  aclip_detector #(.DW(DW)) u_det (
    .clk(clk), .rst(rst),
    .sample_i(sample_i), .sample_vld_i(sample_vld_i),
    .thr_sel_i(thr_sel_i), .en_i(en_i),
    .det_sample_o(det_sample), .det_vld_o(det_vld),
    .det_loud_o(det_loud), .det_en_o(det_en)
  );

  assign attack_req = det_vld & det_loud;

  aclip_gain_ctrl #(
    .MAX_STEPS(MAX_STEPS), .REL_DIV0(REL_DIV0), .REL_DIV1(REL_DIV1),
    .REL_DIV2(REL_DIV2), .REL_DIV3(REL_DIV3), .AW(AW)
  ) u_gain (
    .clk(clk), .rst(rst), .en_i(en_i), .tick_i(tick_i),
    .rel_sel_i(rel_sel_i), .attack_i(attack_req), .atten_o(atten_o)
  );

  aclip_scaler #(.DW(DW), .MAX_STEPS(MAX_STEPS), .AW(AW)) u_scale (
    .clk(clk), .rst(rst),
    .sample_i(det_sample), .vld_i(det_vld), .en_i(det_en),
    .atten_i(atten_o), .sample_o(sample_o), .vld_o(sample_vld_o)
  );

endmodule

// File: rtl/aclip_checker.sv
module aclip_checker #(
  parameter int MAX_STEPS = 24,
  parameter int AW        = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          en_i,
  input logic          sample_vld_i,
  input logic          sample_vld_o,
  input logic          attack_req,
  input logic [AW-1:0] atten_o
);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (atten_o == '0) && !sample_vld_o);

  a_r4_ceiling: assert property (@(posedge clk) disable iff (rst)
    atten_o <= AW'(MAX_STEPS));

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    $past(en_i) |-> (atten_o == $past(atten_o)) ||
                    (atten_o == $past(atten_o) + AW'(1)) ||
                    (atten_o + AW'(1) == $past(atten_o)));

  a_r3_rise_needs_loud: assert property (@(posedge clk) disable iff (rst)
    ($past(en_i) && (atten_o == $past(atten_o) + AW'(1))) |-> $past(attack_req));

  a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !$past(en_i) |-> (atten_o == '0));

  a_r7_strobe_latency: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (sample_vld_o == $past(sample_vld_i, 2)));

endmodule

bind anticlip_limiter aclip_checker #(.MAX_STEPS(MAX_STEPS), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .sample_vld_i(sample_vld_i),
  .sample_vld_o(sample_vld_o), .attack_req(attack_req), .atten_o(atten_o)
);

// File: tb/tb_anticlip_limiter.sv
module tb_anticlip_limiter;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int MAXS = 24;
  localparam int AW   = $clog2(MAXS + 1);
  localparam int D0 = 12, D1 = 8, D2 = 5, D3 = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] sample_i = '0;
  logic          sample_vld_i = 1'b0;
  logic [1:0]    thr_sel_i = 2'd0;
  logic [1:0]    rel_sel_i = 2'd0;
  logic          en_i = 1'b1;
  logic          tick_i = 1'b0;
  logic [DW-1:0] sample_o;
  logic          sample_vld_o;
  logic [AW-1:0] atten_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  anticlip_limiter #(
    .DW(DW), .MAX_STEPS(MAXS), .REL_DIV0(D0), .REL_DIV1(D1),
    .REL_DIV2(D2), .REL_DIV3(D3)
  ) dut (
    .clk(clk), .rst(rst), .sample_i(sample_i), .sample_vld_i(sample_vld_i),
    .thr_sel_i(thr_sel_i), .rel_sel_i(rel_sel_i), .en_i(en_i), .tick_i(tick_i),
    .sample_o(sample_o), .sample_vld_o(sample_vld_o), .atten_o(atten_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference state
  int  m_atten = 0, m_cnt = 0;
  bit  p_vld = 0, p_loud = 0, p_en = 0;
  int  p_x = 0;
  bit  e_vld = 0;
  int  e_out = 0;

  function automatic int trip_of(input int sel);
    real db;
    db = (sel == 0) ? -15.0 : (sel == 1) ? -13.0 : (sel == 2) ? -9.0 : -7.0;
    return $rtoi(32767.0 * (10.0 ** ((db - 3.14) / 20.0)) + 0.5);
  endfunction

  function automatic int div_of(input int sel);
    return (sel == 0) ? D0 : (sel == 1) ? D1 : (sel == 2) ? D2 : D3;
  endfunction

  function automatic int scaled(input int x, input int a);
    longint g;
    longint p;
    g = longint'($rtoi(32768.0 * (10.0 ** (-(real'(a)) / 40.0)) + 0.5));
    p = longint'(x) * g;
    return int'(p >>> 15);
  endfunction

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input int x, input bit tk);
    int xs;
    sample_vld_i = v;
    sample_i     = DW'(x);
    tick_i       = tk;
    xs = $signed(sample_i);
    @(posedge clk);
    if (p_vld) begin
      e_out = p_en ? scaled(p_x, m_atten) : p_x;
      e_vld = 1;
    end else e_vld = 0;
    if (!en_i) begin
      m_atten = 0; m_cnt = 0;
    end else if (p_vld && p_loud) begin
      if (m_atten < MAXS) m_atten++;
      m_cnt = 0;
    end else if (tk) begin
      if (m_cnt >= div_of(rel_sel_i) - 1) begin
        m_cnt = 0;
        if (m_atten > 0) m_atten--;
      end else m_cnt++;
    end
    p_vld = v; p_en = en_i;
    if (v) begin
      p_x = xs;
      p_loud = iabs(xs) > trip_of(thr_sel_i);
    end
    @(negedge clk);
    check(sample_vld_o == e_vld, "output strobe", int'(sample_vld_o), int'(e_vld));
    if (e_vld) check($signed(sample_o) == e_out, "output sample", $signed(sample_o), e_out);
    check(int'(atten_o) == m_atten, "attenuation", int'(atten_o), m_atten);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    check(atten_o == '0, "reset attenuation", int'(atten_o), 0);
    check(sample_vld_o == 1'b0, "reset strobe", int'(sample_vld_o), 0);
    rst = 1'b0;
    cyc(0, 0, 0);

    // R2: trip boundaries for all four selections
    cur_req = "R2";
    for (int s = 0; s < 4; s++) begin
      thr_sel_i = 2'(s);
      en_i = 0; cyc(0, 0, 0); en_i = 1; cyc(0, 0, 0);
      cyc(1, trip_of(s), 0);
      cyc(1, -trip_of(s), 0);
      cyc(0, 0, 0); cyc(0, 0, 0);
      check(int'(atten_o) == 0, "equal to trip is quiet", int'(atten_o), 0);
      cyc(1, trip_of(s) + 1, 0);
      cyc(1, -(trip_of(s) + 1), 0);
      cyc(0, 0, 0); cyc(0, 0, 0);
      check(int'(atten_o) == 2, "above trip attacks", int'(atten_o), 2);
    end

    // R3 and R4: attack every sample, then saturation
    cur_req = "R4";
    thr_sel_i = 2'd0;
    for (int i = 0; i < 40; i++) cyc(1, (i % 2) ? 32767 : -32768, 0);
    cyc(0, 0, 0); cyc(0, 0, 0);
    check(int'(atten_o) == MAXS, "ceiling held", int'(atten_o), MAXS);

    // R5 and R6: release at each rate down to zero, no underflow
    cur_req = "R5";
    for (int s = 3; s >= 0; s--) begin
      rel_sel_i = 2'(s);
      for (int i = 0; i < 3 * div_of(s); i++) cyc(0, 0, 1);
    end
    cur_req = "R6";
    rel_sel_i = 2'd3;
    for (int i = 0; i < 200; i++) cyc(0, 0, 1);
    check(int'(atten_o) == 0, "floor held", int'(atten_o), 0);

    // R9: loud samples colliding with due release steps
    cur_req = "R9";
    for (int i = 0; i < 120; i++) cyc((i % 3) == 2, 30000, 1);

    // R8: disable gives pass-through and zero attenuation
    cur_req = "R8";
    en_i = 0;
    for (int i = 0; i < 30; i++) cyc(1, $signed(16'($urandom)), $urandom_range(0, 1));
    check(int'(atten_o) == 0, "disabled attenuation", int'(atten_o), 0);
    en_i = 1;

    // R7: constrained random traffic
    cur_req = "R7";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 63) == 0) thr_sel_i = 2'($urandom);
      if ($urandom_range(0, 63) == 0) rel_sel_i = 2'($urandom);
      en_i = ($urandom_range(0, 99) != 0);
      cyc($urandom_range(0, 2) != 0,
          ($urandom_range(0, 3) == 0) ? $signed(16'($urandom)) : $urandom_range(0, 6000) - 3000,
          $urandom_range(0, 1));
    end
    en_i = 1;
    cyc(1, -32768, 0); cyc(1, 32767, 0); cyc(0, 0, 0); cyc(0, 0, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule